// File: doc/BRIEF.md
# Sequenced Configuration Lock Controller

This block guards a group of configuration registers with one lock bit. The lock bit can change only through a key sequence on an 8-bit control byte. Software writes 0x46 and then 0x57, and the very next write to the control byte loads the lock from bit 6 of that write. A lock value of 1 blocks writes to the guarded registers. A value of 0 permits them. The lock keeps its value until another full key sequence changes it, so a single unlock session can be used to reprogram every guarded register before the block is locked again.

A static one-way configuration input restricts the block to a single session. While this input is high and the lock is 1, any attempt to clear the lock is ignored, and only a reset returns the lock to 0. While the input is low, the lock can be set and cleared any number of times.

The key sequencer has three states. `SEQ_IDLE` waits for the first key. `SEQ_KEY1` has seen the first key and waits for the second. `SEQ_ARMED` has seen both keys, and its next write is the update write. The transitions all happen on writes only, and a cycle without a write keeps the current state:
- `IDLE->KEY1`: a write of 0x46 from any state.
- `KEY1->ARMED`: a write of 0x57.
- `KEY1->IDLE`: a write of any other value.
- `ARMED->IDLE`: an update write of any value other than 0x46.
- `ARMED->KEY1`: an update write of 0x46. This write also loads the lock.
- `IDLE->IDLE`: a write of any value other than 0x46.

Top module: `cfg_lock_ctrl`

## Requirements
- R1: The lock changes only on the write that immediately follows a write of 0x46 and then a write of 0x57. A write made in any other state never changes the lock.
- R2: The update write loads bit 6 of its data into the lock. `lock_out` is 1 when locked, and `wr_permit` is always the inverse of `lock_out`.
- R3: The lock holds its value on every cycle that is not an update write. It never relocks or unlocks by itself.
- R4: A write that breaks the key order returns the sequencer to `SEQ_IDLE`. A write of 0x46 in any state restarts the sequence at step one.
- R5: While `one_way` is 1 and the lock is 1, an update write with bit 6 equal to 0 leaves the lock at 1.
- R6: The unlock window covers exactly one write. After the update write, further writes do not change the lock until a new key pair is written.
- R7: Reset sets the lock to 0, sets `wr_permit` to 1, and puts the sequencer in `SEQ_IDLE`. With `one_way` at 1, reset is the only way to clear a set lock.
- R8: While `one_way` is 0, the lock can be set and then cleared again through repeated key sequences.
- R9: Cycles with `wr_en` low do not advance or reset the sequencer, so idle cycles may separate the keys and the update write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Data of the control byte write |
| one_way | input | 1 | Static one-way mode select; 1 means a single lock session |
| lock_out | output | 1 | Current lock state; 1 means locked |
| wr_permit | output | 1 | Write permission for the guarded registers |

## Verification
A sequencer stuck in the wrong state shows up at `lock_out` on the first update write that depends on that state. It appears on the clock edge of that write. One example is a write of 0x40 that sets the lock when no key pair preceded it. Another is a key pair that fails to open the window. Faults in the one-way path or in window closing show up as a lock that clears, or stays changed, one write later than the requirements allow. The vector table therefore checks the lock after every single write, and no write goes unchecked.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_KEY1  = 2'd1,
        SEQ_ARMED = 2'd2
    } seq_state_t;

endpackage

// File: rtl/cfg_lock_keyseq.sv
module cfg_lock_keyseq
    import cfg_lock_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter logic [7:0]  KEY_A  = 8'h46,
    parameter logic [7:0]  KEY_B  = 8'h57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              armed
);

    localparam logic [DATA_W-1:0] KA = DATA_W'(KEY_A);
    localparam logic [DATA_W-1:0] KB = DATA_W'(KEY_B);

    seq_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic: moves only on writes
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (state_q)
                SEQ_IDLE:  state_d = (wr_data == KA) ? SEQ_KEY1 : SEQ_IDLE;
                SEQ_KEY1:  begin
                    if (wr_data == KB)      state_d = SEQ_ARMED;
                    else if (wr_data == KA) state_d = SEQ_KEY1;
                    else                    state_d = SEQ_IDLE;
                end
                SEQ_ARMED: state_d = (wr_data == KA) ? SEQ_KEY1 : SEQ_IDLE;
                default:   state_d = SEQ_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        armed = (state_q == SEQ_ARMED);
    end

endmodule

// File: rtl/cfg_lock_reg.sv
module cfg_lock_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic new_val,
    input  logic one_way,
    output logic lock_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (upd) begin
            if (new_val)                 lock_q <= 1'b1;
            else if (!(one_way && lock_q)) lock_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl #(
    parameter int          DATA_W   = 8,
    parameter int          LOCK_BIT = 6,
    parameter logic [7:0]  KEY_A    = 8'h46,
    parameter logic [7:0]  KEY_B    = 8'h57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              one_way,
    output logic              lock_out,
    output logic              wr_permit
);

    logic armed;
    logic upd;

    cfg_lock_keyseq #(
        .DATA_W (DATA_W),
        .KEY_A  (KEY_A),
        .KEY_B  (KEY_B)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .armed   (armed)
    );

    assign upd = wr_en && armed;

    cfg_lock_reg u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (upd),
        .new_val (wr_data[LOCK_BIT]),
        .one_way (one_way),
        .lock_q  (lock_out)
    );

    assign wr_permit = ~lock_out;

endmodule

// File: rtl/cfg_lock_chk.sv
module cfg_lock_chk #(
    parameter int          DATA_W   = 8,
    parameter int          LOCK_BIT = 6,
    parameter logic [7:0]  KEY_B    = 8'h57
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              one_way,
    input logic              lock_out,
    input logic              wr_permit,
    input logic              armed
);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && armed) |=> $stable(lock_out));

    assert_arm_after_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(wr_en && (wr_data == DATA_W'(KEY_B))));

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && armed && wr_data[LOCK_BIT]) |=> lock_out);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && armed && !wr_data[LOCK_BIT] && !one_way) |=> !lock_out);

    assert_one_way_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (one_way && lock_out) |=> lock_out);

    assert_single_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && armed) |=> !armed);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(armed));

    assert_permit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit != lock_out);

endmodule

bind cfg_lock_ctrl cfg_lock_chk #(
    .DATA_W   (DATA_W),
    .LOCK_BIT (LOCK_BIT),
    .KEY_B    (KEY_B)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .one_way   (one_way),
    .lock_out  (lock_out),
    .wr_permit (wr_permit),
    .armed     (armed)
);

// File: tb/cfg_lock_ctrl_bench.sv
module cfg_lock_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       one_way = 1'b0;
    logic       lock_out;
    logic       wr_permit;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    cfg_lock_ctrl u_cfg_lock_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .one_way   (one_way),
        .lock_out  (lock_out),
        .wr_permit (wr_permit)
    );

    // vector: {one_way, data[7:0], expected lock after the write}
    localparam int NV = 30;
    localparam logic [9:0] VEC [NV] = '{
        {1'b0, 8'h46, 1'b0}, {1'b0, 8'h57, 1'b0}, {1'b0, 8'h40, 1'b1}, // R2 set
        {1'b0, 8'h00, 1'b1},                                            // R3 hold
        {1'b0, 8'h46, 1'b1}, {1'b0, 8'h57, 1'b1}, {1'b0, 8'h00, 1'b0}, // R8 clear
        {1'b0, 8'h40, 1'b0},                                            // R1 no key
        {1'b0, 8'h57, 1'b0}, {1'b0, 8'h40, 1'b0},                       // R1 second key alone
        {1'b0, 8'h46, 1'b0}, {1'b0, 8'h12, 1'b0}, {1'b0, 8'h57, 1'b0},
        {1'b0, 8'h40, 1'b0},                                            // R4 broken order
        {1'b0, 8'h46, 1'b0}, {1'b0, 8'h46, 1'b0}, {1'b0, 8'h57, 1'b0},
        {1'b0, 8'h40, 1'b1},                                            // R4 restart
        {1'b0, 8'h46, 1'b1}, {1'b0, 8'h57, 1'b1}, {1'b0, 8'h46, 1'b1},
        {1'b0, 8'h57, 1'b1}, {1'b0, 8'h00, 1'b0},                       // R6 update of key A rearms
        {1'b0, 8'h46, 1'b0}, {1'b0, 8'h57, 1'b0}, {1'b0, 8'h40, 1'b1},
        {1'b0, 8'h00, 1'b1},                                            // R6 window closed
        {1'b1, 8'h46, 1'b1}, {1'b1, 8'h57, 1'b1}, {1'b1, 8'h00, 1'b1}  // R5 one-way
    };

    task automatic check(input string req, input logic exp_lock);
        n_vec++;
        if (lock_out !== exp_lock || wr_permit !== ~exp_lock) begin
            n_bad++;
            $display("FAIL %s: lock=%b permit=%b expected lock=%b permit=%b",
                     req, lock_out, wr_permit, exp_lock, ~exp_lock);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check("R7 reset", 1'b0);

        for (int i = 0; i < NV; i++) begin
            one_way = VEC[i][9];
            do_write(VEC[i][8:1]);
            check($sformatf("vector %0d (R1..R8 table)", i), VEC[i][0]);
        end

        // R7: only reset clears a one-way lock
        do_reset();
        check("R7 reset clears one-way lock", 1'b0);

        // R5: one-way session set then clear attempt
        do_write(8'h46); do_write(8'h57); do_write(8'h00);
        check("R5 clear while unlocked", 1'b0);
        do_write(8'h46); do_write(8'h57); do_write(8'h40);
        check("R5 one-way set", 1'b1);
        do_write(8'h46); do_write(8'h57); do_write(8'h00);
        check("R5 one-way clear ignored", 1'b1);
        do_write(8'hBF); // bit 6 clear, not a key value
        check("R5 stray write", 1'b1);

        // R9: idle cycles between keys and update
        one_way = 1'b0;
        do_reset();
        do_write(8'h46); idle(3);
        do_write(8'h57); idle(4);
        check("R9 idle before update", 1'b0);
        do_write(8'h40);
        check("R9 update after gaps", 1'b1);
        idle(10);
        check("R3 lock holds over idle", 1'b1);

        // R8: second unlimited session
        do_write(8'h46); do_write(8'h57); do_write(8'h00);
        check("R8 second clear", 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule